// File: doc/BRIEF.md
# Register Scoreboard Issue Interlock

This block decides, one decoded instruction at a time, whether an instruction may leave the decode stage of a small processor back end. The back end has two execution units: an adder unit that finishes in one cycle and a multiplier that needs two. The block holds one busy flag per architectural register. A flag means that an instruction already in execution will write that register. An instruction may issue only if none of the registers it reads and none of the registers it writes is flagged. Otherwise the stall output is raised, and the front end must present the same instruction again on the next cycle.

The block models the latency of both units with internal timing pipelines. It reports each completion on a per-unit port together with the register being written, and that completion clears the register's flag. A completion that falls in the same cycle as an issue check is visible to that check. Units of unequal latency run at the same time, so a younger add can finish while an older multiply is still running, or in the very same cycle. Register 0 is hardwired: it never becomes busy and never blocks anything.

Top module: `sb_issue_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all busy flags are cleared and both timing pipelines are emptied. After reset, no completion is reported, and an instruction that reads a register targeted before the reset issues at once.
- R2: With `in_valid` high and no conflict, `issue_valid` is 1 and `stall` is 0 in the same cycle. With `in_valid` low, both outputs are 0.
- R3: An instruction whose source register (A or B, nonzero) is flagged busy and is not being cleared in that cycle gets `stall`=1 and `issue_valid`=0.
- R4: An instruction issued with `in_unit`=0 (add) has `add_done`=1 and `add_done_reg` equal to its destination in the cycle after the issue cycle.
- R5: An instruction issued with `in_unit`=1 (multiply) has `mul_done`=1 and `mul_done_reg` equal to its destination two cycles after the issue cycle.
- R6: A completion clears its register's flag with effect in the same cycle. An add that reads the result of the add issued just before it issues with no gap. An instruction that reads a multiply result issues two cycles after the multiply.
- R7: An instruction whose destination register (nonzero) is flagged busy and is not being cleared in that cycle stalls.
- R8: Register 0 is never flagged busy. Reading it or writing it never causes a stall.
- R9: When a completion and an issue name the same register in one cycle, the flag stays set, because the new writer takes priority over the clear.
- R10: Both completion ports may report in the same cycle. A younger add then finishes no later than an older multiply, and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 1 | Target unit: 0 add, 1 multiply |
| in_dst | input | 5 | Destination register index |
| in_src_a | input | 5 | First source register index |
| in_src_b | input | 5 | Second source register index |
| stall | output | 1 | Presented instruction must wait |
| issue_valid | output | 1 | Presented instruction issues this cycle |
| add_done | output | 1 | Adder unit completes this cycle |
| add_done_reg | output | 5 | Register written by the adder completion |
| mul_done | output | 1 | Multiplier completes this cycle |
| mul_done_reg | output | 5 | Register written by the multiplier completion |

## Verification
`stall` and `issue_valid` depend combinationally on the presented instruction and on the flags as seen in the current cycle. The bench therefore drives inputs on the falling edge and samples both outputs 1 ns later in the same cycle. An add issued in cycle T must show on `add_done` in T+1, and a multiply issued in cycle T must show on `mul_done` in T+2. The bench's reference model shifts its own add and multiply records by exactly those amounts at each rising edge, and it compares them against the completion ports at the same mid-cycle sample point. The model applies the clears of a cycle before it evaluates that cycle's hazards, and it applies the set of an issue after the clears.

// File: rtl/sb_pkg.sv
// Shared definitions for the scoreboard issue interlock.
// Assumes the register count is a power of two.
package sb_pkg;
    typedef enum logic {
        UNIT_ADD = 1'b0,
        UNIT_MUL = 1'b1
    } unit_e;
endpackage

// File: rtl/sb_exec_timer.sv
// Latency model of one execution unit. A start pulse with its destination
// register travels through LAT stages and appears on done/done_reg LAT
// cycles after the start cycle. Assumes at most one start per cycle.
module sb_exec_timer #(
    parameter int LAT = 1,
    parameter int AW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_reg,
    output logic          done,
    output logic [AW-1:0] done_reg
);
    logic          stg_v [LAT];
    logic [AW-1:0] stg_r [LAT];

    // Shift the in-flight records one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                stg_v[i] <= 1'b0;
                stg_r[i] <= '0;
            end
        end else begin
            stg_v[0] <= start;
            stg_r[0] <= start_reg;
            for (int i = 1; i < LAT; i++) begin
                stg_v[i] <= stg_v[i-1];
                stg_r[i] <= stg_r[i-1];
            end
        end
    end

    assign done     = stg_v[LAT-1];
    assign done_reg = stg_r[LAT-1];
endmodule

// File: rtl/sb_busy_table.sv
// Busy-flag table. One flag per register: it is set when a writer issues
// and cleared when that writer completes. A set takes priority over a
// clear of the same register in one cycle. busy_eff is the view with this
// cycle's clears already applied, which the hazard check uses. Register 0
// is never flagged.
module sb_busy_table #(
    parameter int NREG = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [AW-1:0]   set_reg,
    input  logic            clr0_en,
    input  logic [AW-1:0]   clr0_reg,
    input  logic            clr1_en,
    input  logic [AW-1:0]   clr1_reg,
    output logic [NREG-1:0] busy_q,
    output logic [NREG-1:0] busy_eff
);
    logic [NREG-1:0] clr_mask;
    logic [NREG-1:0] set_mask;

    // Decode the set and clear targets per register.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign clr_mask[g] = (clr0_en && (clr0_reg == AW'(g))) ||
                             (clr1_en && (clr1_reg == AW'(g)));
        assign set_mask[g] = set_en && (set_reg == AW'(g)) && (g != 0);
    end

    assign busy_eff = busy_q & ~clr_mask;

    // Apply the clears first, then the sets, so a new writer wins.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_eff | set_mask;
    end

    // R8
    assert property (@(posedge clk) disable iff (!rst_n) !busy_q[0])
        else $error("reg0_never_busy_chk");

    // R8
    reg0_never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q[0]);

    // R6
    clr0_targets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0_en && clr0_reg != '0) |-> busy_q[clr0_reg]);

    // R6
    clr1_targets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr1_en && clr1_reg != '0) |-> busy_q[clr1_reg]);

    // R10
    dual_clr_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0_en && clr1_en && clr0_reg != '0) |-> (clr0_reg != clr1_reg));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_reg != '0) |=> busy_q[$past(set_reg)]);
endmodule

// File: rtl/sb_hazard_check.sv
// Combinational hazard detection for the presented instruction. It flags a
// read-after-write conflict on either nonzero source and a write-after-write
// conflict on a nonzero destination, using the busy view with this cycle's
// clears applied.
module sb_hazard_check #(
    parameter int NREG = 32,
    parameter int AW   = 5
) (
    input  logic            valid,
    input  logic [NREG-1:0] busy_eff,
    input  logic [AW-1:0]   src_a,
    input  logic [AW-1:0]   src_b,
    input  logic [AW-1:0]   dst,
    output logic            raw_hit,
    output logic            waw_hit
);
    logic a_hit, b_hit;

    // Look up each named register in the busy view.
    always_comb begin
        a_hit   = (src_a != '0) && busy_eff[src_a];
        b_hit   = (src_b != '0) && busy_eff[src_b];
        raw_hit = valid && (a_hit || b_hit);
        waw_hit = valid && (dst != '0) && busy_eff[dst];
    end
endmodule

// File: rtl/sb_issue_ctl.sv
// Top level of the scoreboard issue interlock. It accepts one decoded
// instruction per cycle and issues it when no source or destination
// register is owned by an in-flight writer; otherwise it stalls. It models
// an adder unit of ADD_LAT cycles and a multiplier of MUL_LAT cycles and
// reports their completions. Assumes the front end holds a stalled
// instruction until it issues.
module sb_issue_ctl #(
    parameter int NREG    = 32,
    parameter int ADD_LAT = 1,
    parameter int MUL_LAT = 2,
    localparam int AW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_unit,
    input  logic [AW-1:0] in_dst,
    input  logic [AW-1:0] in_src_a,
    input  logic [AW-1:0] in_src_b,
    output logic          stall,
    output logic          issue_valid,
    output logic          add_done,
    output logic [AW-1:0] add_done_reg,
    output logic          mul_done,
    output logic [AW-1:0] mul_done_reg
);
    import sb_pkg::*;

    unit_e           unit;
    logic [NREG-1:0] busy_q, busy_eff;
    logic            raw_hit, waw_hit;
    logic            add_start, mul_start;

    // Decode the unit select and form the issue decision.
    always_comb begin
        unit        = unit_e'(in_unit);
        stall       = raw_hit || waw_hit;
        issue_valid = in_valid && !stall;
        add_start   = issue_valid && (unit == UNIT_ADD);
        mul_start   = issue_valid && (unit == UNIT_MUL);
    end

    sb_hazard_check #(.NREG(NREG), .AW(AW)) u_haz (
        .valid    (in_valid),
        .busy_eff (busy_eff),
        .src_a    (in_src_a),
        .src_b    (in_src_b),
        .dst      (in_dst),
        .raw_hit  (raw_hit),
        .waw_hit  (waw_hit)
    );

    sb_busy_table #(.NREG(NREG), .AW(AW)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue_valid),
        .set_reg  (in_dst),
        .clr0_en  (add_done),
        .clr0_reg (add_done_reg),
        .clr1_en  (mul_done),
        .clr1_reg (mul_done_reg),
        .busy_q   (busy_q),
        .busy_eff (busy_eff)
    );

    sb_exec_timer #(.LAT(ADD_LAT), .AW(AW)) u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (add_start),
        .start_reg (in_dst),
        .done      (add_done),
        .done_reg  (add_done_reg)
    );

    sb_exec_timer #(.LAT(MUL_LAT), .AW(AW)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mul_start),
        .start_reg (in_dst),
        .done      (mul_done),
        .done_reg  (mul_done_reg)
    );

    // R2
    issue_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid || stall) |-> in_valid);

    // R3
    src_a_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && in_src_a != '0) |->
        (!busy_q[in_src_a] || (add_done && add_done_reg == in_src_a) ||
         (mul_done && mul_done_reg == in_src_a)));

    // R7
    dst_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && in_dst != '0) |->
        (!busy_q[in_dst] || (add_done && add_done_reg == in_dst) ||
         (mul_done && mul_done_reg == in_dst)));

    // R4
    if (ADD_LAT == 1) begin : g_add_chk
        add_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            add_start |=> (add_done && add_done_reg == $past(in_dst)));
    end

    // R5
    if (MUL_LAT == 2) begin : g_mul_chk
        mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mul_start |=> ##1 mul_done);
    end
endmodule

// File: tb/tb_sb_issue_ctl.sv
`timescale 1ns/1ps
module tb_sb_issue_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_unit = 1'b0;
    logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic       stall, issue_valid, add_done, mul_done;
    logic [4:0] add_done_reg, mul_done_reg;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // Reference model state
    bit       m_busy [32];
    bit       m_add_v;
    int       m_add_r;
    bit       m_mul_v [2];
    int       m_mul_r [2];
    bit       last_iss;

    always #4 clk = ~clk;

    sb_issue_ctl dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .stall(stall), .issue_valid(issue_valid),
        .add_done(add_done), .add_done_reg(add_done_reg),
        .mul_done(mul_done), .mul_done_reg(mul_done_reg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit eff_busy(input int r);
        return m_busy[r] && !(m_add_v && m_add_r == r) &&
               !(m_mul_v[1] && m_mul_r[1] == r);
    endfunction

    task automatic model_clear();
        for (int r = 0; r < 32; r++) m_busy[r] = 1'b0;
        m_add_v = 1'b0; m_add_r = 0;
        for (int s = 0; s < 2; s++) begin m_mul_v[s] = 1'b0; m_mul_r[s] = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // One cycle: drive on the falling edge, check mid-cycle, advance model.
    task automatic step(input bit v, input bit u, input int d, input int sa,
                        input int sb, input string tag);
        bit raw, waw, es, ei;
        bit nb [32];
        string rq, cq;
        @(negedge clk);
        in_valid = v; in_unit = u; in_dst = 5'(d);
        in_src_a = 5'(sa); in_src_b = 5'(sb);
        #1;
        raw = v && ((sa != 0 && eff_busy(sa)) || (sb != 0 && eff_busy(sb)));
        waw = v && d != 0 && eff_busy(d);
        es  = raw || waw;
        ei  = v && !es;
        if (tag != "") rq = tag;
        else if (raw)  rq = "R3";
        else if (waw)  rq = "R7";
        else           rq = "R2";
        chk(stall == es, rq, "stall", stall, es);
        chk(issue_valid == ei, rq, "issue_valid", issue_valid, ei);
        cq = (tag == "R1" || tag == "R10") ? tag : "R4";
        chk(add_done == m_add_v, cq, "add_done", add_done, m_add_v);
        if (m_add_v) chk(add_done_reg == 5'(m_add_r), cq, "add_done_reg",
                         add_done_reg, m_add_r);
        cq = (tag == "R1" || tag == "R10") ? tag : "R5";
        chk(mul_done == m_mul_v[1], cq, "mul_done", mul_done, m_mul_v[1]);
        if (m_mul_v[1]) chk(mul_done_reg == 5'(m_mul_r[1]), cq, "mul_done_reg",
                            mul_done_reg, m_mul_r[1]);
        // advance model: clears first, then set
        for (int r = 0; r < 32; r++) nb[r] = eff_busy(r);
        if (ei && d != 0) nb[d] = 1'b1;
        for (int r = 0; r < 32; r++) m_busy[r] = nb[r];
        m_add_v = ei && !u; m_add_r = d;
        m_mul_v[1] = m_mul_v[0]; m_mul_r[1] = m_mul_r[0];
        m_mul_v[0] = ei && u;   m_mul_r[0] = d;
        last_iss = ei;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0, "");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();
        // R1: nothing reported after reset, outputs idle
        step(1'b0, 1'b0, 0, 0, 0, "R1");
        step(1'b1, 1'b0, 3, 5, 6, "R1");
        idle(2);
        // R1: flags of in-flight writer dropped by reset
        step(1'b1, 1'b1, 9, 1, 2, "R2");
        do_reset();
        step(1'b1, 1'b0, 4, 9, 9, "R1");
        chk(last_iss, "R1", "issue after reset", last_iss, 1);
        idle(2);
        // R6: back-to-back dependent adds
        step(1'b1, 1'b0, 1, 2, 3, "R2");
        step(1'b1, 1'b0, 4, 1, 1, "R6");
        chk(last_iss, "R6", "dependent add issue", last_iss, 1);
        idle(2);
        // R3 then R6: dependent of multiply waits one cycle
        step(1'b1, 1'b1, 5, 2, 3, "R2");
        step(1'b1, 1'b0, 6, 5, 0, "R3");
        chk(!last_iss, "R3", "raw stall", last_iss, 0);
        step(1'b1, 1'b0, 6, 5, 0, "R6");
        chk(last_iss, "R6", "issue on mul completion", last_iss, 1);
        idle(2);
        // R7: destination owned by multiply
        step(1'b1, 1'b1, 7, 2, 3, "R2");
        step(1'b1, 1'b0, 7, 0, 0, "R7");
        chk(!last_iss, "R7", "waw stall", last_iss, 0);
        step(1'b1, 1'b0, 7, 0, 0, "R7");
        idle(2);
        // R8: register 0 never busy
        step(1'b1, 1'b1, 0, 2, 3, "R8");
        step(1'b1, 1'b0, 0, 0, 0, "R8");
        chk(last_iss, "R8", "reg0 no stall", last_iss, 1);
        step(1'b1, 1'b1, 0, 0, 0, "R8");
        idle(3);
        // R9: new writer on the completing register keeps it busy
        step(1'b1, 1'b1, 8, 2, 3, "R2");
        idle(1);
        step(1'b1, 1'b1, 8, 2, 3, "R9");
        chk(last_iss, "R9", "reissue on clearing dst", last_iss, 1);
        step(1'b1, 1'b0, 9, 8, 0, "R9");
        chk(!last_iss, "R9", "flag kept after set+clear", last_iss, 0);
        idle(3);
        // R10: younger add finishes with older multiply
        step(1'b1, 1'b1, 10, 2, 3, "R2");
        step(1'b1, 1'b0, 11, 2, 3, "R2");
        step(1'b0, 1'b0, 0, 0, 0, "R10");
        step(1'b1, 1'b0, 12, 10, 11, "R10");
        chk(last_iss, "R10", "both flags cleared", last_iss, 1);
        idle(2);
        // Constrained random mix over a small register window
        for (int i = 0; i < 4000; i++) begin
            bit v;
            v = ($urandom % 10) < 8;
            step(v, 1'($urandom), int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % 8), "");
        end
        idle(3);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule